// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the byte stream of each received Ethernet frame and classifies the frame by its destination address. It compares the first six bytes of the frame against a configured 48-bit station address and detects broadcast and group (multicast) destinations. When the frame ends, it reports one four-bit status word. The block never discards a frame. It only reports whether the frame would pass the address filter and whether the frame arrived with an error, so that later logic or software can choose what to keep.

Three mode inputs change the verdict. Promiscuous mode accepts any destination. The broadcast-reject mode makes all-ones destinations fail the filter. The keep-errored mode lets a frame with an error still report its true filter result instead of a forced failure.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `stat_valid` is 0 and `stat_word` is 0.
- R2: `stat_valid` is 1 in exactly the cycle after each cycle in which `rx_eof` is 1, and 0 in every other cycle.
- R3: The status word is `{pf, ff, mcast, bcast}` with pf in bit 3 and bcast in bit 0. An error-free frame whose six destination bytes equal `station_addr` reports ff=0 and pf=0. The first byte received is compared with `station_addr[47:40]` and the sixth with `station_addr[7:0]`.
- R4: An error-free frame outside promiscuous mode reports ff=1 when any of its six destination bytes differs from the matching station address byte and the destination is not all ones.
- R5: A destination of six bytes of 8'hFF sets bcast=1 and mcast=0. Outside promiscuous mode, such a frame passes (ff=0) when `no_bcast`=0 and fails (ff=1) when `no_bcast`=1.
- R6: A destination that is not all ones and has bit 0 of its first byte set reports mcast=1. Such a frame passes the filter only on an exact match with the station address.
- R7: With `promisc`=1, any error-free frame that carries six destination bytes reports ff=0, including a broadcast frame while `no_bcast`=1.
- R8: A frame with `rx_err`=1 in its end cycle reports pf=1. When `pass_bad`=0 it also reports ff=1. When `pass_bad`=1 its ff is the filter result the frame would have without the error.
- R9: A frame that ends before six destination bytes have been received reports pf=1, ff=1 and bcast=0 under every mode setting. Its mcast bit is bit 0 of its first byte, or 0 if no byte arrived.
- R10: `rx_sof` clears all address state, and a byte valid in the same cycle is taken as the first destination byte. A byte valid in the `rx_eof` cycle counts. Bytes after the sixth do not affect the status.
- R11: In every cycle where `stat_valid` is 0, `stat_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Start of frame strobe; clears address state |
| rx_vld | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End of frame strobe |
| rx_err | input | 1 | Frame error flag, sampled with rx_eof |
| station_addr | input | 48 | Station address, first-received byte in bits 47:40 |
| promisc | input | 1 | Accept every destination |
| no_bcast | input | 1 | Make broadcast destinations fail the filter |
| pass_bad | input | 1 | Report the true filter result for errored frames |
| stat_valid | output | 1 | One-cycle pulse marking stat_word valid |
| stat_word | output | 4 | {pf, ff, mcast, bcast} |

## Verification
The hardest cases to reach are the ones where the frame boundaries do not line up with the six-byte address window. These include a frame that ends after fewer than six bytes, a frame that starts in the cycle right after the previous one ended, and stray bytes that arrive between frames with no start strobe. The stimulus drives such frames directly: short frames of zero and three bytes, a frame followed at once by the next one, and loose bytes injected before a proper start. A behavioural queue model keeps every byte seen since the last start strobe and predicts the status from the first six of them. The same frames are repeated under each combination of modes that changes the verdict.

// File: rtl/eth_af_pkg.sv
package eth_af_pkg;
  typedef struct packed {
    logic pf;
    logic ff;
    logic mcast;
    logic bcast;
  } af_status_t;
endpackage

// File: rtl/eth_af_addr_track.sv
module eth_af_addr_track #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sof,
  input  logic                         vld,
  input  logic [BYTE_W-1:0]            data,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station,
  output logic                         nxt_full,
  output logic                         nxt_any,
  output logic                         nxt_match,
  output logic                         nxt_ones,
  output logic                         nxt_grp
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(ADDR_BYTES);

  logic [BYTE_W-1:0] sa_b [ADDR_BYTES];
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_split
    assign sa_b[g] = station[(ADDR_BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  logic [CW-1:0] idx_q, idx_b, idx_n;
  logic match_q, ones_q, grp_q;
  logic match_b, ones_b, grp_b;
  logic match_n, ones_n, grp_n;
  logic take;

  always_comb begin
    idx_b   = sof ? '0   : idx_q;
    match_b = sof ? 1'b1 : match_q;
    ones_b  = sof ? 1'b1 : ones_q;
    grp_b   = sof ? 1'b0 : grp_q;
    idx_n   = idx_b;
    match_n = match_b;
    ones_n  = ones_b;
    grp_n   = grp_b;
    take    = vld && (idx_b < LAST);
    if (take) begin
      match_n = match_b && (data == sa_b[idx_b]);
      ones_n  = ones_b && (&data);
      if (idx_b == '0) grp_n = data[0];
      idx_n   = idx_b + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      match_q <= 1'b1;
      ones_q  <= 1'b1;
      grp_q   <= 1'b0;
    end else begin
      idx_q   <= idx_n;
      match_q <= match_n;
      ones_q  <= ones_n;
      grp_q   <= grp_n;
    end
  end

  assign nxt_full  = (idx_n == LAST);
  assign nxt_any   = (idx_n != '0);
  assign nxt_match = match_n;
  assign nxt_ones  = ones_n;
  assign nxt_grp   = grp_n;

  // R10: the byte index never runs past the address window
  a_r10_idx_bound: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST);

  // R10: a start strobe with no byte leaves the window empty
  a_r10_sof_clear: assert property (@(posedge clk) disable iff (rst)
    (sof && !vld) |=> (idx_q == '0));
endmodule

// File: rtl/eth_af_status.sv
module eth_af_status
  import eth_af_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       eof,
  input  logic       err,
  input  logic       promisc,
  input  logic       no_bcast,
  input  logic       pass_bad,
  input  logic       full,
  input  logic       any,
  input  logic       match,
  input  logic       ones,
  input  logic       grp,
  output logic       stat_valid,
  output af_status_t stat
);
  af_status_t calc;
  logic is_bc, pass, bad;

  always_comb begin
    is_bc      = full && ones;
    pass       = promisc || (is_bc ? !no_bcast : (full && match));
    bad        = err || !full;
    calc.bcast = is_bc;
    calc.mcast = any && grp && !is_bc;
    calc.pf    = bad;
    calc.ff    = !full || !pass || (bad && !pass_bad);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid <= 1'b0;
      stat       <= '0;
    end else begin
      stat_valid <= eof;
      stat       <= eof ? calc : '0;
    end
  end

  // R2: one status pulse follows each end strobe
  a_r2_pulse: assert property (@(posedge clk) disable iff (rst)
    eof |=> stat_valid);
  a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
    !eof |=> !stat_valid);

  // R7: promiscuous accepts every complete, clean destination
  a_r7_promisc: assert property (@(posedge clk) disable iff (rst)
    (eof && promisc && full && !err) |=> !stat.ff);

  // R8: an errored frame always raises pf
  a_r8_err_pf: assert property (@(posedge clk) disable iff (rst)
    (eof && err) |=> stat.pf);

  // R9: a short frame is flagged bad and failed
  a_r9_short: assert property (@(posedge clk) disable iff (rst)
    (eof && !full) |=> (stat.pf && stat.ff && !stat.bcast));
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eth_af_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rx_sof,
  input  logic                         rx_vld,
  input  logic [BYTE_W-1:0]            rx_data,
  input  logic                         rx_eof,
  input  logic                         rx_err,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
  input  logic                         promisc,
  input  logic                         no_bcast,
  input  logic                         pass_bad,
  output logic                         stat_valid,
  output logic [3:0]                   stat_word
);
  logic full, any, match, ones, grp;
  af_status_t st;

  eth_af_addr_track #(
    .ADDR_BYTES (ADDR_BYTES),
    .BYTE_W     (BYTE_W)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .sof       (rx_sof),
    .vld       (rx_vld),
    .data      (rx_data),
    .station   (station_addr),
    .nxt_full  (full),
    .nxt_any   (any),
    .nxt_match (match),
    .nxt_ones  (ones),
    .nxt_grp   (grp)
  );

  eth_af_status u_status (
    .clk        (clk),
    .rst        (rst),
    .eof        (rx_eof),
    .err        (rx_err),
    .promisc    (promisc),
    .no_bcast   (no_bcast),
    .pass_bad   (pass_bad),
    .full       (full),
    .any        (any),
    .match      (match),
    .ones       (ones),
    .grp        (grp),
    .stat_valid (stat_valid),
    .stat       (st)
  );

  assign stat_word = st;

  // R11: the word is zero whenever no pulse is present
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !stat_valid |-> (stat_word == 4'd0));
endmodule

// File: tb/eth_rx_addr_filter_bench.sv
module eth_rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_sof = 0, rx_vld = 0, rx_eof = 0, rx_err = 0;
  logic [7:0]  rx_data = '0;
  logic [47:0] station_addr = 48'h02_1A_2B_3C_4D_5E;
  logic        promisc = 0, no_bcast = 0, pass_bad = 0;
  logic        stat_valid;
  logic [3:0]  stat_word;

  int    total = 0, bad = 0;
  bit    done  = 0;
  string cur_req = "R3";

  always #10 clk = ~clk;

  eth_rx_addr_filter u_eth_rx_addr_filter (
    .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_data(rx_data),
    .rx_eof(rx_eof), .rx_err(rx_err), .station_addr(station_addr),
    .promisc(promisc), .no_bcast(no_bcast), .pass_bad(pass_bad),
    .stat_valid(stat_valid), .stat_word(stat_word)
  );

  // behavioural reference: bytes since last start, verdict at end strobe
  logic [7:0] seen[$];
  bit         exp_vld = 0;
  logic [3:0] exp_word = '0;
  string      exp_tag = "R11";

  always @(posedge clk) begin
    if (rst) begin
      seen.delete(); exp_vld = 0; exp_word = '0; exp_tag = "R1";
    end else begin
      if (rx_sof) seen.delete();
      if (rx_vld) seen.push_back(rx_data);
      exp_vld = rx_eof; exp_word = '0; exp_tag = "R11";
      if (rx_eof) begin
        int  n;
        bit  full, ones, hit, grp, bc, mc, pas, er, ff;
        n = seen.size();
        full = (n >= 6); ones = 1; hit = 1;
        for (int i = 0; i < 6 && i < n; i++) begin
          if (seen[i] != 8'hFF) ones = 0;
          if (seen[i] != station_addr[47-8*i -: 8]) hit = 0;
        end
        grp = (n > 0) && seen[0][0];
        bc  = full && ones;
        mc  = grp && !bc;
        pas = promisc || (bc ? !no_bcast : (full && hit));
        er  = rx_err || !full;
        ff  = !full || !pas || (er && !pass_bad);
        exp_word = {er, ff, mc, bc};
        if (!full)        exp_tag = "R9";
        else if (rx_err)  exp_tag = "R8";
        else if (promisc) exp_tag = "R7";
        else if (bc)      exp_tag = "R5";
        else if (mc)      exp_tag = "R6";
        else if (hit)     exp_tag = "R3";
        else              exp_tag = "R4";
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (stat_valid !== exp_vld) begin
        bad++;
        $display("FAIL R2 (%s) stat_valid actual=%0b expected=%0b", cur_req, stat_valid, exp_vld);
      end
      total++;
      if (stat_word !== exp_word) begin
        bad++;
        $display("FAIL %s (%s) stat_word actual=%b expected=%b", exp_tag, cur_req, stat_word, exp_word);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_sof = 0; rx_vld = 0; rx_eof = 0; rx_err = 0;
    end
  endtask

  task automatic frame(input logic [7:0] b[$], input bit err, input int gap);
    if (b.size() == 0) begin
      @(negedge clk);
      rx_sof = 1; rx_vld = 0; rx_eof = 1; rx_err = err;
    end else begin
      for (int i = 0; i < b.size(); i++) begin
        @(negedge clk);
        rx_sof = (i == 0); rx_vld = 1; rx_data = b[i];
        rx_eof = (i == b.size() - 1); rx_err = err && rx_eof;
      end
    end
    idle(gap);
  endtask

  logic [7:0] own[$], bcq[$], oth[$], grpq[$], shortq[$], noneq[$], longq[$];

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    own    = '{8'h02, 8'h1A, 8'h2B, 8'h3C, 8'h4D, 8'h5E, 8'h77, 8'h88};
    bcq    = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h01};
    oth    = '{8'h02, 8'h1A, 8'h2B, 8'h3C, 8'h4D, 8'h5F, 8'h00};
    grpq   = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01, 8'h10};
    shortq = '{8'hFF, 8'hFF, 8'hFF};
    noneq  = {};
    longq  = '{8'h02, 8'h1A, 8'h2B, 8'h3C, 8'h4D, 8'h5E, 8'hFF, 8'hFF, 8'hFF, 8'h01};

    cur_req = "R1";
    repeat (3) @(negedge clk);
    total++;
    if (stat_valid !== 0 || stat_word !== 0) begin
      bad++;
      $display("FAIL R1 reset actual=%b/%b expected=0/0000", stat_valid, stat_word);
    end
    @(negedge clk); rst = 0;
    idle(2);

    cur_req = "R3"; frame(own, 0, 2);
    cur_req = "R4"; frame(oth, 0, 1);
    oth[0] = 8'h12; frame(oth, 0, 1);
    cur_req = "R5"; frame(bcq, 0, 1);
    no_bcast = 1;   frame(bcq, 0, 1);
    cur_req = "R6"; frame(grpq, 0, 1);
    station_addr = 48'h01_00_5E_00_00_01; frame(grpq, 0, 1);
    station_addr = 48'h02_1A_2B_3C_4D_5E;
    cur_req = "R7"; promisc = 1;
    frame(oth, 0, 1); frame(bcq, 0, 1); frame(grpq, 0, 1);
    cur_req = "R8"; promisc = 0; no_bcast = 0;
    frame(own, 1, 1); frame(oth, 1, 1);
    pass_bad = 1; frame(own, 1, 1); frame(oth, 1, 1); frame(bcq, 1, 1);
    cur_req = "R9"; pass_bad = 0;
    frame(shortq, 0, 1); frame(noneq, 0, 1);
    promisc = 1; pass_bad = 1; frame(shortq, 0, 1); frame(grpq[0:2], 1, 1);
    promisc = 0; pass_bad = 0;
    cur_req = "R10";
    frame(longq, 0, 0); frame(own, 0, 0); frame(oth, 0, 0);
    frame(shortq, 0, 0);
    @(negedge clk); rx_vld = 1; rx_data = 8'h02;
    @(negedge clk); rx_data = 8'h33;
    frame(own, 0, 1);
    @(negedge clk); rx_sof = 1; rx_vld = 0; rx_eof = 0;
    frame(own[1:7], 0, 1);
    cur_req = "R11"; idle(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule